// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches virtual-to-physical translations for fixed 4 KB pages in a set-associative array. A requester presents a virtual address with a flag that chooses whether a hit refreshes recency. One clock later the block returns a registered response. On a hit, the response holds the physical address and the page attributes: writable, user, global and uncacheable. The physical address is the stored physical page number joined with the low 12 bits of the virtual address.

A page walker or a higher-level agent fills the cache. It does so with an insert port that carries a virtual page number and a complete entry. Within a set, a fill first takes the lowest-numbered free way. When the set is full, the fill replaces the least recently used entry. Every way of a set carries a recency age, and age 0 means most recently used.

Three maintenance commands remove entries:
- a full flush, which removes every entry;
- a selective flush, which removes only the entries that are not global;
- a single-page demap, which removes one page.

None of these commands disturbs the recency order of the entries that remain. Inserting a page that is already present is not supported; the caller demaps the page first.

Top module: `tlb_sa_top`

## Requirements
- R1: The set of an address is bits [12 +: log2(SETS)] of the virtual address. Pages that differ only above those bits compete for the ways of one set, and they never evict entries of another set.
- R2: A lookup accepted in cycle n gives `rsp_valid` high in cycle n+1, and `rsp_valid` is low after a cycle with no lookup. A hit returns `{ppn, vaddr[11:0]}` together with the entry's four attribute bits.
- R3: A lookup that matches no valid entry returns `rsp_hit`=0, with the physical address and all attribute outputs at zero.
- R4: While the indexed set has a free way, an insert takes a free way and evicts nothing.
- R5: An insert into a full set replaces the least recently used entry of that set.
- R6: A newly inserted entry becomes the most recently used entry of its set.
- R7: A hit with `lk_touch`=1 makes the hit entry the most recently used entry of its set.
- R8: A lookup with `lk_touch`=0 leaves the recency order unchanged.
- R9: A full flush makes every entry of every set invalid in one cycle.
- R10: A selective flush removes only the entries whose global bit is 0. Global entries keep their relative recency order.
- R11: A demap removes the entry that holds the addressed page, if one exists. The order of the other entries is unchanged, and a demap of an absent page has no effect.
- R12: When more than one maintenance or fill command is raised in a cycle, exactly one of them acts. The priority runs from full flush, to selective flush, to demap, to insert, and the lower commands are dropped.
- R13: When an insert and a lookup address the same set in one cycle, the lookup response reflects the contents before the insert. The lookup's recency promotion is dropped, and the inserted entry becomes the most recently used entry.
- R14: During reset and after it, every entry is invalid and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_touch | input | 1 | Promote the entry to most recently used on a hit |
| ins_valid | input | 1 | Insert request |
| ins_vpn | input | VA_W-12 | Virtual page number to insert |
| ins_ppn | input | PA_W-12 | Physical page number of the new entry |
| ins_writable | input | 1 | Writable attribute of the new entry |
| ins_user | input | 1 | User attribute of the new entry |
| ins_global | input | 1 | Global attribute of the new entry |
| ins_uncached | input | 1 | Uncacheable attribute of the new entry |
| flush_all | input | 1 | Invalidate every entry |
| flush_local | input | 1 | Invalidate the entries that are not global |
| demap_valid | input | 1 | Remove one page |
| demap_vaddr | input | VA_W | Address inside the page to remove |
| rsp_valid | output | 1 | Response strobe, one cycle after a lookup |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | PA_W | Translated physical address |
| rsp_writable | output | 1 | Writable attribute of the hit entry |
| rsp_user | output | 1 | User attribute of the hit entry |
| rsp_global | output | 1 | Global attribute of the hit entry |
| rsp_uncached | output | 1 | Uncacheable attribute of the hit entry |

## Verification
The directed tests fill one set past its capacity in three different ways, and each one tells a different recency rule apart:
- a plain fill, which gives pure insertion order;
- a fill after a touching hit, which shows that promotion takes effect;
- a fill after a non-touching hit, which shows that the order stays where it was.

The next eviction identifies which entry was oldest in each case.

A same-cycle insert and touching lookup separates R13 from an implementation that applies both updates, because the entry that survives the next fill differs between the two. Colliding command pairs show which command wins under R12. A mix of global and non-global entries shows the selective flush, and a later fill checks that the global entries kept their order.

A long pseudo-random phase with a small page pool produces heavy same-set reuse. In that phase, every response is compared against an ordered-list reference model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef struct packed {
    logic writable;
    logic user;
    logic global_pg;
    logic uncached;
  } tlb_attr_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_FLUSH_ALL,
    OP_FLUSH_LOCAL,
    OP_DEMAP,
    OP_FILL
  } tlb_op_e;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  parameter int WAY_W = 2
) (
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [WAYS-1:0]       valid,
  input  logic [TAG_W-1:0]      key,
  output logic [WAYS-1:0]       hit_vec,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way
);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid[w] && (tags[w*TAG_W +: TAG_W] == key);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  free_mask,
  input  logic [WAY_W-1:0] lru_way,
  output logic [WAY_W-1:0] victim_way
);

  logic             any_free;
  logic [WAY_W-1:0] first_free;

  always_comb begin
    first_free = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (free_mask[w]) first_free = WAY_W'(w);
    end
  end

  assign any_free   = |free_mask;
  assign victim_way = any_free ? first_free : lru_way;

endmodule

// File: rtl/tlb_recency.sv
module tlb_recency #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] lru_way
);

  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic [WAYS-1:0][WAY_W-1:0] age_q, age_d;
  logic [WAY_W-1:0]           touched_age;
  logic [WAYS-1:0]            age_seen;

  assign touched_age = age_q[touch_way];

  always_comb begin
    age_d = age_q;
    if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)       age_d[w] = '0;
        else if (age_q[w] < touched_age)  age_d[w] = age_q[w] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) age_q[w] <= WAY_W'(w);
    end else if (touch_en) begin
      age_q <= age_d;
    end
  end

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_q[w] == OLDEST) lru_way = WAY_W'(w);
    end
  end

  always_comb begin
    age_seen = '0;
    for (int w = 0; w < WAYS; w++) age_seen[age_q[w]] = 1'b1;
  end

  // R6 / R7: a touched way is youngest next cycle
  assert_touch_mru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> age_q[$past(touch_way)] == '0);

  // R8: untouched sets keep their order
  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !touch_en |=> $stable(age_q));

  // R5: ages remain a permutation, so the oldest way is unique
  assert_age_perm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(age_seen) == WAYS);

endmodule

// File: rtl/tlb_sa_top.sv
module tlb_sa_top #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRIES    = 16,
  parameter int WAYS       = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lk_valid,
  input  logic [VA_W-1:0]            lk_vaddr,
  input  logic                       lk_touch,
  input  logic                       ins_valid,
  input  logic [VA_W-PAGE_SHIFT-1:0] ins_vpn,
  input  logic [PA_W-PAGE_SHIFT-1:0] ins_ppn,
  input  logic                       ins_writable,
  input  logic                       ins_user,
  input  logic                       ins_global,
  input  logic                       ins_uncached,
  input  logic                       flush_all,
  input  logic                       flush_local,
  input  logic                       demap_valid,
  input  logic [VA_W-1:0]            demap_vaddr,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic [PA_W-1:0]            rsp_paddr,
  output logic                       rsp_writable,
  output logic                       rsp_user,
  output logic                       rsp_global,
  output logic                       rsp_uncached
);
  import tlb_pkg::*;

  localparam int SETS  = ENTRIES / WAYS;
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int VPN_W = VA_W - PAGE_SHIFT;
  localparam int PPN_W = PA_W - PAGE_SHIFT;
  localparam logic [SET_W-1:0] SET_MASK = SET_W'(SETS - 1);

  // ---------------- storage ----------------
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  valid_d [SETS];
  logic [VPN_W-1:0] tag_q   [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q   [SETS][WAYS];
  tlb_attr_t        attr_q  [SETS][WAYS];

  // ---------------- command decode ----------------
  tlb_op_e          op;
  logic             fill_en;
  logic [VPN_W-1:0] lk_vpn, dm_vpn;
  logic [SET_W-1:0] lk_set, dm_set, ins_set;

  assign lk_vpn  = lk_vaddr[VA_W-1:PAGE_SHIFT];
  assign dm_vpn  = demap_vaddr[VA_W-1:PAGE_SHIFT];
  assign lk_set  = lk_vpn[SET_W-1:0] & SET_MASK;
  assign dm_set  = dm_vpn[SET_W-1:0] & SET_MASK;
  assign ins_set = ins_vpn[SET_W-1:0] & SET_MASK;

  always_comb begin
    if (flush_all)        op = OP_FLUSH_ALL;
    else if (flush_local) op = OP_FLUSH_LOCAL;
    else if (demap_valid) op = OP_DEMAP;
    else if (ins_valid)   op = OP_FILL;
    else                  op = OP_NONE;
  end
  assign fill_en = (op == OP_FILL);

  // ---------------- tag match ----------------
  logic [WAYS*VPN_W-1:0] lk_tags, dm_tags;
  logic [WAYS-1:0]       lk_hitv, dm_hitv;
  logic                  lk_hit, dm_hit;
  logic [WAY_W-1:0]      lk_way, dm_way;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_tags[w*VPN_W +: VPN_W] = tag_q[lk_set][w];
      dm_tags[w*VPN_W +: VPN_W] = tag_q[dm_set][w];
    end
  end

  tlb_match #(.WAYS(WAYS), .TAG_W(VPN_W), .WAY_W(WAY_W)) u_lk_match (
    .tags(lk_tags), .valid(valid_q[lk_set]), .key(lk_vpn),
    .hit_vec(lk_hitv), .hit(lk_hit), .hit_way(lk_way));

  tlb_match #(.WAYS(WAYS), .TAG_W(VPN_W), .WAY_W(WAY_W)) u_dm_match (
    .tags(dm_tags), .valid(valid_q[dm_set]), .key(dm_vpn),
    .hit_vec(dm_hitv), .hit(dm_hit), .hit_way(dm_way));

  // ---------------- replacement ----------------
  logic [WAY_W-1:0] lru_way    [SETS];
  logic [SETS-1:0]  touch_en;
  logic [WAY_W-1:0] touch_way  [SETS];
  logic [WAY_W-1:0] vic_way;

  tlb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .free_mask(~valid_q[ins_set]), .lru_way(lru_way[ins_set]),
    .victim_way(vic_way));

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      if (fill_en && ins_set == SET_W'(s)) begin
        touch_en[s]  = 1'b1;
        touch_way[s] = vic_way;
      end else begin
        touch_en[s]  = lk_valid && lk_touch && lk_hit && (lk_set == SET_W'(s));
        touch_way[s] = lk_way;
      end
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    tlb_recency #(.WAYS(WAYS), .WAY_W(WAY_W)) u_rec (
      .clk(clk), .rst_n(rst_n), .touch_en(touch_en[s]),
      .touch_way(touch_way[s]), .lru_way(lru_way[s]));
  end

  // ---------------- valid next state ----------------
  always_comb begin
    for (int s = 0; s < SETS; s++) valid_d[s] = valid_q[s];
    unique case (op)
      OP_FLUSH_ALL: begin
        for (int s = 0; s < SETS; s++) valid_d[s] = '0;
      end
      OP_FLUSH_LOCAL: begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            if (valid_q[s][w] && !attr_q[s][w].global_pg) valid_d[s][w] = 1'b0;
      end
      OP_DEMAP: begin
        if (dm_hit) valid_d[dm_set][dm_way] = 1'b0;
      end
      OP_FILL: begin
        valid_d[ins_set][vic_way] = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= valid_d[s];
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[ins_set][vic_way]  <= ins_vpn;
      ppn_q[ins_set][vic_way]  <= ins_ppn;
      attr_q[ins_set][vic_way] <= '{writable: ins_writable, user: ins_user,
                                    global_pg: ins_global, uncached: ins_uncached};
    end
  end

  // ---------------- response ----------------
  logic            rsp_valid_q, rsp_hit_q, rsp_hit_d;
  logic [PA_W-1:0] rsp_pa_q, rsp_pa_d;
  tlb_attr_t       rsp_attr_q, rsp_attr_d;

  always_comb begin
    rsp_hit_d  = lk_hit;
    rsp_pa_d   = '0;
    rsp_attr_d = '0;
    if (lk_hit) begin
      rsp_pa_d   = {ppn_q[lk_set][lk_way], lk_vaddr[PAGE_SHIFT-1:0]};
      rsp_attr_d = attr_q[lk_set][lk_way];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid_q <= 1'b0;
    else        rsp_valid_q <= lk_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit_q  <= 1'b0;
      rsp_pa_q   <= '0;
      rsp_attr_q <= '0;
    end else if (lk_valid) begin
      rsp_hit_q  <= rsp_hit_d;
      rsp_pa_q   <= rsp_pa_d;
      rsp_attr_q <= rsp_attr_d;
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_hit      = rsp_hit_q;
  assign rsp_paddr    = rsp_pa_q;
  assign rsp_writable = rsp_attr_q.writable;
  assign rsp_user     = rsp_attr_q.user;
  assign rsp_global   = rsp_attr_q.global_pg;
  assign rsp_uncached = rsp_attr_q.uncached;

  // ---------------- assertions ----------------
  logic any_valid, local_valid;
  always_comb begin
    any_valid   = 1'b0;
    local_valid = 1'b0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        any_valid   = any_valid | valid_q[s][w];
        local_valid = local_valid | (valid_q[s][w] & ~attr_q[s][w].global_pg);
      end
  end

  assert_rsp_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && !rsp_writable && !rsp_user
                                 && !rsp_global && !rsp_uncached));
  assert_one_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hitv) && $onehot0(dm_hitv));
  assert_flush_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !any_valid);
  assert_flush_local_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_local && !flush_all) |=> !local_valid);

endmodule

// File: tb/tlb_sa_top_tb_top.sv
module tlb_sa_top_tb_top;

  localparam int VA_W = 32, PA_W = 32, PS = 12, ENTRIES = 16, WAYS = 4;
  localparam int SETS = ENTRIES / WAYS;

  typedef struct {
    bit [VA_W-PS-1:0] vpn;
    bit [PA_W-PS-1:0] ppn;
    bit [3:0]         attr; // {writable,user,global,uncached}
  } ment_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic              lk_valid, lk_touch, ins_valid, ins_writable, ins_user, ins_global, ins_uncached;
  logic              flush_all, flush_local, demap_valid;
  logic [VA_W-1:0]   lk_vaddr, demap_vaddr;
  logic [VA_W-PS-1:0] ins_vpn;
  logic [PA_W-PS-1:0] ins_ppn;
  logic              rsp_valid, rsp_hit, rsp_writable, rsp_user, rsp_global, rsp_uncached;
  logic [PA_W-1:0]   rsp_paddr;

  tlb_sa_top #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PS), .ENTRIES(ENTRIES), .WAYS(WAYS)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_touch(lk_touch),
    .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn), .ins_writable(ins_writable),
    .ins_user(ins_user), .ins_global(ins_global), .ins_uncached(ins_uncached),
    .flush_all(flush_all), .flush_local(flush_local), .demap_valid(demap_valid),
    .demap_vaddr(demap_vaddr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .rsp_writable(rsp_writable), .rsp_user(rsp_user), .rsp_global(rsp_global),
    .rsp_uncached(rsp_uncached));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  ment_t mq [SETS][$]; // index 0 = most recently used

  function automatic int set_of(bit [VA_W-PS-1:0] vpn);
    return int'(vpn) % SETS;
  endfunction

  function automatic int find(int s, bit [VA_W-PS-1:0] vpn);
    for (int i = 0; i < mq[s].size(); i++) if (mq[s][i].vpn == vpn) return i;
    return -1;
  endfunction

  function automatic bit [VA_W-1:0] mkva(int tag, int s, int off);
    return (VA_W'(tag) << (PS + 2)) | (VA_W'(s) << PS) | VA_W'(off & 12'hfff);
  endfunction

  task automatic idle();
    lk_valid = 0; lk_touch = 0; lk_vaddr = '0; ins_valid = 0; ins_vpn = '0; ins_ppn = '0;
    {ins_writable, ins_user, ins_global, ins_uncached} = '0;
    flush_all = 0; flush_local = 0; demap_valid = 0; demap_vaddr = '0;
  endtask

  // one clock: inputs already set by caller at a negedge; model then compare
  task automatic tick(string req);
    bit exp_v, exp_h; bit [PA_W-1:0] exp_pa; bit [3:0] exp_at;
    int ls, li, ds, di, is_;
    bit fill;
    exp_v = lk_valid; exp_h = 0; exp_pa = '0; exp_at = '0;
    ls = set_of(lk_vaddr[VA_W-1:PS]);
    li = lk_valid ? find(ls, lk_vaddr[VA_W-1:PS]) : -1;
    if (li >= 0) begin
      exp_h = 1; exp_pa = {mq[ls][li].ppn, lk_vaddr[PS-1:0]}; exp_at = mq[ls][li].attr;
    end
    is_  = set_of(ins_vpn);
    fill = ins_valid && !flush_all && !flush_local && !demap_valid;
    // lookup promotion (dropped if fill hits the same set: R13)
    if (li >= 0 && lk_touch && !(fill && is_ == ls)) begin
      ment_t e = mq[ls][li]; mq[ls].delete(li); mq[ls].push_front(e);
    end
    if (flush_all) begin
      for (int s = 0; s < SETS; s++) mq[s].delete();
    end else if (flush_local) begin
      for (int s = 0; s < SETS; s++) begin
        ment_t keep[$];
        foreach (mq[s][i]) if (mq[s][i].attr[1]) keep.push_back(mq[s][i]);
        mq[s] = keep;
      end
    end else if (demap_valid) begin
      ds = set_of(demap_vaddr[VA_W-1:PS]);
      di = find(ds, demap_vaddr[VA_W-1:PS]);
      if (di >= 0) mq[ds].delete(di);
    end else if (ins_valid) begin
      ment_t e;
      e.vpn = ins_vpn; e.ppn = ins_ppn;
      e.attr = {ins_writable, ins_user, ins_global, ins_uncached};
      if (mq[is_].size() >= WAYS) void'(mq[is_].pop_back());
      mq[is_].push_front(e);
    end
    @(negedge clk);
    n_cmp++;
    if (rsp_valid !== exp_v ||
        (exp_v && (rsp_hit !== exp_h || rsp_paddr !== exp_pa ||
         {rsp_writable, rsp_user, rsp_global, rsp_uncached} !== exp_at))) begin
      n_bad++;
      $display("FAIL %s: got v%0b h%0b pa=%h at=%b, expected v%0b h%0b pa=%h at=%b", req,
               rsp_valid, rsp_hit, rsp_paddr, {rsp_writable, rsp_user, rsp_global, rsp_uncached},
               exp_v, exp_h, exp_pa, exp_at);
    end
    idle();
  endtask

  task automatic look(int tag, int s, bit touch, string req);
    lk_valid = 1; lk_touch = touch; lk_vaddr = mkva(tag, s, tag * 97 + 5);
    tick(req);
  endtask

  task automatic put(int tag, int s, bit [3:0] at);
    ins_valid = 1; ins_vpn = mkva(tag, s, 0) >> PS; ins_ppn = (PA_W-PS)'(tag * 16 + s + 8'h40);
    {ins_writable, ins_user, ins_global, ins_uncached} = at;
  endtask

  task automatic probe_set(int s, int maxtag, string req);
    for (int t = 0; t <= maxtag; t++) look(t, s, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    n_cmp++; // R14 reset state
    if (rsp_valid !== 1'b0) begin
      n_bad++; $display("FAIL R14: got rsp_valid=%b, expected 0", rsp_valid);
    end
    rst_n = 1;
    @(negedge clk);
    probe_set(1, 3, "R14 empty after reset");
    tick("R2 idle cycle has no response");

    // R4: fill a set, no eviction
    for (int t = 0; t < 4; t++) begin put(t, 1, 4'(t * 5)); tick("R4 fill"); end
    probe_set(1, 3, "R4 all ways kept");
    look(2, 1, 0, "R2 translation and attributes");
    look(9, 1, 0, "R3 miss");
    // R1: other set unaffected by overflow of set 1
    put(0, 2, 4'b1010); tick("R1 fill set2");
    put(4, 1, 4'b0001); tick("R5 evict oldest");
    probe_set(1, 4, "R5 after eviction");
    look(0, 2, 0, "R1 other set intact");
    look(0, 3, 0, "R1 same tag other set misses");
    // R7: touching hit promotes
    look(1, 1, 1, "R7 touch");
    put(5, 1, 4'b0110); tick("R6 fill");
    probe_set(1, 5, "R7 promoted entry survives");
    // R8: non-touching hit leaves order
    look(3, 1, 0, "R8 probe");
    put(6, 1, 4'b0011); tick("R8 fill");
    probe_set(1, 6, "R8 probed entry evicted");
    // R13: same-cycle insert and touching lookup in one set
    look(1, 1, 1, "R7 touch before R13");
    lk_valid = 1; lk_touch = 1; lk_vaddr = mkva(5, 1, 3); put(7, 1, 4'b1000);
    tick("R13 lookup sees prior contents");
    put(8, 1, 4'b0100); tick("R13 fill");
    probe_set(1, 8, "R13 promotion dropped");
    // R11: demap
    demap_valid = 1; demap_vaddr = mkva(8, 1, 0); tick("R11 demap");
    demap_valid = 1; demap_vaddr = mkva(30, 1, 0); tick("R11 demap absent");
    probe_set(1, 8, "R11 after demap");
    put(9, 1, 4'b0000); tick("R4 refill freed way");
    put(10, 1, 4'b0000); tick("R11 order kept");
    probe_set(1, 10, "R11 order of others kept");
    // R10: selective flush
    put(0, 0, 4'b0010); tick("R10 fill global");
    put(1, 0, 4'b0000); tick("R10 fill local");
    put(2, 0, 4'b0010); tick("R10 fill global");
    put(3, 0, 4'b1000); tick("R10 fill local");
    look(0, 0, 1, "R10 touch");
    flush_local = 1; tick("R10 selective flush");
    probe_set(0, 3, "R10 only global kept");
    put(4, 0, 4'b0); tick("R10 fill");
    put(5, 0, 4'b0); tick("R10 fill");
    put(6, 0, 4'b0); tick("R10 fill");
    probe_set(0, 6, "R10 global order preserved");
    // R12: priority
    flush_local = 1; put(7, 0, 4'b0); tick("R12 flush beats insert");
    demap_valid = 1; demap_vaddr = mkva(0, 0, 0); put(8, 0, 4'b0); tick("R12 demap beats insert");
    flush_all = 1; flush_local = 1; demap_valid = 1; demap_vaddr = mkva(2, 0, 0);
    tick("R12 full flush wins");
    probe_set(0, 8, "R12 after collisions");
    // R9
    put(3, 3, 4'b1111); tick("R9 fill");
    flush_all = 1; tick("R9 flush all");
    for (int s = 0; s < SETS; s++) probe_set(s, 10, "R9 all invalid");

    // random mix
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 70) begin
        lk_valid = 1; lk_touch = $urandom_range(0, 1);
        lk_vaddr = mkva($urandom_range(0, 6), $urandom_range(0, 3), $urandom_range(0, 4095));
      end
      r = $urandom_range(0, 99);
      if (r < 35) begin
        int t, s;
        t = $urandom_range(0, 6); s = $urandom_range(0, 3);
        if (find(s, VA_W'(mkva(t, s, 0) >> PS)) < 0)
          put(t, s, 4'($urandom_range(0, 15)));
      end
      r = $urandom_range(0, 99);
      if (r < 10) begin
        demap_valid = 1; demap_vaddr = mkva($urandom_range(0, 6), $urandom_range(0, 3), 0);
      end
      r = $urandom_range(0, 199);
      if (r < 3) flush_local = 1;
      if (r == 5) flush_all = 1;
      tick("R5 R7 R13 random mix");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule